// File: doc/BRIEF.md
# Serial Command Decoder for a Digital Potentiometer

This block is the serial slave front end of a digitally controlled potentiometer. It runs on a fast system clock and treats the serial interface pins as asynchronous inputs. Each pin passes through a synchronizer, and edges of the serial clock are found by oversampling. A transaction starts when the select line falls. The block then reads a device identification byte and an instruction byte, and for some commands a third byte. The master may also keep clocking to step the wiper up and down with no fixed limit. The serial clock half period must be at least `SYNC_STAGES + 4` system clock cycles.

Decoded commands leave the block as single-cycle requests on a plain request port. A request carries an operation code, a 4-bit register address and write data. This port leads to the wiper register and to a 16-entry register file of four banks with four registers each. For a read, the storage answers on `rsp_data` one cycle after the request. The block then shifts that byte out most significant bit first. Read-out starts on the falling serial clock edge that follows the 16th rising edge.

A pause input freezes the shift sequence without losing its place. The output enable is low whenever the device is deselected, paused, or not in a read-out phase, so the pad can be left floating.

Top module: `pot_spi_decoder`

## Requirements
- R1: A frame proceeds only if its first byte, received MSB first, equals `0101_00_{addr_strap[1],addr_strap[0]}`. Any other first byte makes the block ignore the rest of the frame until the select line rises, with `spi_miso_oe` low.
- R2: The second byte carries the instruction in bits [7:4], the register select in bits [3:2] and the bank in bits [1:0]. The request address is `cmd_addr = {bank, register}`, with the bank in the upper two bits.
- R3: Instructions map to `cmd_op` codes as follows: 1001 gives 0 (read wiper), 1010 gives 1 (write wiper), 1011 gives 2 (read register), 1100 gives 3 (write register), 1101 gives 4 (register to wiper), 1110 gives 5 (wiper to register). Instruction 0010 gives 6 (step up) or 7 (step down).
- R4: A write command issues exactly one request, carrying the third byte on `cmd_wdata`, after the 24th rising edge. If the select line rises earlier, no request is made.
- R5: Read commands issue their request after the 16th bit. The response byte is driven on `spi_miso` MSB first, and each bit changes after a falling serial clock edge, so the master samples it on the following rising edge.
- R6: Instruction 0101 reads status. It makes no request and returns `0000000w`, where `w` is `wip_in` sampled when the instruction byte completes.
- R7: Wiper, transfer and step instructions with a nonzero bank make no request and leave `spi_miso_oe` low. Register read and write accept any bank.
- R8: After instruction 0010, every rising serial clock edge issues one request: op 6 if the data input is 1, op 7 if it is 0. This continues until the select line rises.
- R9: The two transfer instructions issue their request after the 16th bit and need no third byte.
- R10: `spi_miso_oe` is low while the device is deselected and outside the read-out phase.
- R11: With `pause_n` low while the serial clock is low, serial clock edges are ignored. Shifting resumes at the same bit once `pause_n` returns high while the serial clock is low.
- R12: After reset, a falling edge of the select line is needed before any frame is decoded. If the line is already low at reset, clocking in bits has no effect.
- R13: Instruction codes outside the eight listed above make no request and leave `spi_miso_oe` low.
- R14: Right after reset, `cmd_valid` and `spi_miso_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel_n | input | 1 | Active-low device select |
| spi_clk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from the master |
| pause_n | input | 1 | Active-low pause of the serial stream |
| addr_strap | input | 2 | Strapped device address bits |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| cmd_valid | output | 1 | Single-cycle request strobe |
| cmd_op | output | 3 | Request operation code |
| cmd_addr | output | 4 | Bank and register of the request |
| cmd_wdata | output | 8 | Write data of the request |
| rsp_data | input | 8 | Read response, valid one cycle after a read request |
| wip_in | input | 1 | Write-in-progress flag from storage |

## Verification
Complete frames are sent for every instruction. These show that each opcode and bank/register field turns into the right operation and address, and that read data come back in order on the output. Frames that differ in one detail are sent next to them: a wrong address bit in the first byte, a nonzero bank on a wiper command, an undefined opcode, a frame cut off after 20 bits, and a frame clocked in with no select edge after reset. Each shows that a specific guard stops the request. A step sequence with mixed data bits checks the direction count. A write frame interrupted by pulses on the serial clock during a pause shows that a frozen stream keeps its bit position.

// File: rtl/pot_spi_pkg.sv
package pot_spi_pkg;
  localparam int BYTE_W  = 8;
  localparam int OPC_W   = 4;
  localparam int SEL_W   = 2;
  localparam int BANK_W  = 2;
  localparam int ADDR_W  = SEL_W + BANK_W;
  localparam int STRAP_W = 2;

  typedef enum logic [2:0] {
    OP_RD_WIPER   = 3'd0,
    OP_WR_WIPER   = 3'd1,
    OP_RD_REG     = 3'd2,
    OP_WR_REG     = 3'd3,
    OP_LOAD_WIPER = 3'd4,
    OP_SAVE_WIPER = 3'd5,
    OP_STEP_UP    = 3'd6,
    OP_STEP_DN    = 3'd7
  } req_op_e;

  localparam logic [OPC_W-1:0] INS_RD_WIPER = 4'b1001;
  localparam logic [OPC_W-1:0] INS_WR_WIPER = 4'b1010;
  localparam logic [OPC_W-1:0] INS_RD_REG   = 4'b1011;
  localparam logic [OPC_W-1:0] INS_WR_REG   = 4'b1100;
  localparam logic [OPC_W-1:0] INS_LOAD     = 4'b1101;
  localparam logic [OPC_W-1:0] INS_SAVE     = 4'b1110;
  localparam logic [OPC_W-1:0] INS_STEP     = 4'b0010;
  localparam logic [OPC_W-1:0] INS_STATUS   = 4'b0101;

  typedef enum logic [2:0] {
    FS_IDLE, FS_DEVID, FS_INSTR, FS_WDATA, FS_RDOUT, FS_STEP, FS_SKIP
  } frame_st_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pot_cmd_fsm.sv
module pot_cmd_fsm
  import pot_spi_pkg::*;
#(
  parameter logic [OPC_W-1:0] DEV_TYPE = 4'b0101
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_n_s,
  input  logic                sclk_s,
  input  logic                mosi_s,
  input  logic                pause_n_s,
  input  logic [STRAP_W-1:0]  addr_strap,
  input  logic                wip_in,
  output logic                cmd_valid,
  output logic [2:0]          cmd_op,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [BYTE_W-1:0]   cmd_wdata,
  output logic                fall_ok,
  output logic                rd_phase,
  output logic                paused,
  output logic                ld_rsp,
  output logic                ld_stat,
  output logic [BYTE_W-1:0]   stat_byte
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  frame_st_e          st;
  req_op_e            pend_op;
  req_op_e            op_q;
  logic               sel_q, sclk_q, rd_wait;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  shreg;

  logic selected, sel_fall, rise_ok, byte_done;
  logic [BYTE_W-1:0] in_byte, id_expect;
  logic [OPC_W-1:0]  ins_op;
  logic [ADDR_W-1:0] ins_addr;
  logic              ins_bank0;

  assign selected  = ~sel_n_s;
  assign sel_fall  = sel_q & ~sel_n_s;
  assign rise_ok   = selected & ~paused & sclk_s & ~sclk_q;
  assign fall_ok   = selected & ~paused & ~sclk_s & sclk_q;
  assign in_byte   = {shreg[BYTE_W-2:0], mosi_s};
  assign byte_done = (bit_cnt == LAST_BIT);
  assign id_expect = {DEV_TYPE, 2'b00, addr_strap};
  assign ins_op    = in_byte[BYTE_W-1 -: OPC_W];
  assign ins_addr  = {in_byte[BANK_W-1:0], in_byte[BANK_W +: SEL_W]};
  assign ins_bank0 = (in_byte[BANK_W-1:0] == '0);
  assign rd_phase  = (st == FS_RDOUT);
  assign cmd_op    = op_q;

  // pause tracks the pause input, changing only while the serial clock is low
  always_ff @(posedge clk) begin
    if (rst) begin
      paused <= 1'b0;
      sel_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= sel_n_s;
      sclk_q <= sclk_s;
      if (!selected)    paused <= 1'b0;
      else if (!sclk_s) paused <= ~pause_n_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FS_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      pend_op   <= OP_WR_WIPER;
      op_q      <= OP_RD_WIPER;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      rd_wait   <= 1'b0;
      ld_rsp    <= 1'b0;
      ld_stat   <= 1'b0;
      stat_byte <= '0;
    end else begin
      cmd_valid <= 1'b0;
      ld_stat   <= 1'b0;
      rd_wait   <= 1'b0;
      ld_rsp    <= rd_wait;
      if (sel_fall) begin
        st      <= FS_DEVID;
        bit_cnt <= '0;
      end else if (!selected) begin
        st <= FS_IDLE;
      end else if (rise_ok) begin
        unique case (st)
          FS_DEVID: begin
            shreg   <= in_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) st <= (in_byte == id_expect) ? FS_INSTR : FS_SKIP;
          end
          FS_INSTR: begin
            shreg   <= in_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
              cmd_addr <= ins_addr;
              st       <= FS_SKIP;
              case (ins_op)
                INS_RD_WIPER: if (ins_bank0) begin
                  cmd_valid <= 1'b1; op_q <= OP_RD_WIPER; rd_wait <= 1'b1; st <= FS_RDOUT;
                end
                INS_RD_REG: begin
                  cmd_valid <= 1'b1; op_q <= OP_RD_REG; rd_wait <= 1'b1; st <= FS_RDOUT;
                end
                INS_WR_WIPER: if (ins_bank0) begin
                  pend_op <= OP_WR_WIPER; st <= FS_WDATA;
                end
                INS_WR_REG: begin
                  pend_op <= OP_WR_REG; st <= FS_WDATA;
                end
                INS_LOAD: if (ins_bank0) begin
                  cmd_valid <= 1'b1; op_q <= OP_LOAD_WIPER;
                end
                INS_SAVE: if (ins_bank0) begin
                  cmd_valid <= 1'b1; op_q <= OP_SAVE_WIPER;
                end
                INS_STEP: if (ins_bank0) st <= FS_STEP;
                INS_STATUS: begin
                  ld_stat   <= 1'b1;
                  stat_byte <= {{(BYTE_W-1){1'b0}}, wip_in};
                  st        <= FS_RDOUT;
                end
                default: st <= FS_SKIP;
              endcase
            end
          end
          FS_WDATA: begin
            shreg   <= in_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
              cmd_valid <= 1'b1;
              op_q      <= pend_op;
              cmd_wdata <= in_byte;
              st        <= FS_SKIP;
            end
          end
          FS_STEP: begin
            cmd_valid <= 1'b1;
            op_q      <= mosi_s ? OP_STEP_UP : OP_STEP_DN;
          end
          default: ;
        endcase
      end
    end
  end

  p_req_needs_select_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(selected));

  p_bank0_only_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_op inside {OP_RD_WIPER, OP_WR_WIPER, OP_LOAD_WIPER,
                                 OP_SAVE_WIPER, OP_STEP_UP, OP_STEP_DN})
    |-> (cmd_addr[ADDR_W-1 -: BANK_W] == '0));

  p_hold_freezes_r11: assert property (@(posedge clk) disable iff (rst)
    paused |=> !cmd_valid);

  p_rsp_after_req_r5: assert property (@(posedge clk) disable iff (rst)
    ld_rsp |-> $past(cmd_valid));
endmodule

// File: rtl/pot_sdo_shift.sv
module pot_sdo_shift
  import pot_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              selected,
  input  logic              paused,
  input  logic              rd_phase,
  input  logic              fall_ok,
  input  logic              ld_rsp,
  input  logic [BYTE_W-1:0] rsp_data,
  input  logic              ld_stat,
  input  logic [BYTE_W-1:0] stat_byte,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [BYTE_W-1:0] out_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sh <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo_oe <= rd_phase & selected & ~paused;
      if (ld_rsp)       out_sh <= rsp_data;
      else if (ld_stat) out_sh <= stat_byte;
      else if (rd_phase && fall_ok) out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
      if (!rd_phase)    sdo <= 1'b0;
      else if (fall_ok) sdo <= out_sh[BYTE_W-1];
    end
  end

  p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    rd_phase && !fall_ok |=> $stable(sdo));
endmodule

// File: rtl/pot_spi_decoder.sv
module pot_spi_decoder
  import pot_spi_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [OPC_W-1:0]  DEV_TYPE    = 4'b0101
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        spi_sel_n,
  input  logic        spi_clk,
  input  logic        spi_mosi,
  input  logic        pause_n,
  input  logic [1:0]  addr_strap,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  output logic        cmd_valid,
  output logic [2:0]  cmd_op,
  output logic [3:0]  cmd_addr,
  output logic [7:0]  cmd_wdata,
  input  logic [7:0]  rsp_data,
  input  logic        wip_in
);
  // synchronized pins: {pause_n, mosi, sclk, sel_n}; select resets low so a
  // line held low through reset never shows a falling edge
  logic [3:0] pins_s;
  logic fall_ok, rd_phase, paused, ld_rsp, ld_stat;
  logic [BYTE_W-1:0] stat_byte;

  spi_in_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pause_n, spi_mosi, spi_clk, spi_sel_n}),
    .q   (pins_s)
  );

  pot_cmd_fsm #(.DEV_TYPE(DEV_TYPE)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sel_n_s    (pins_s[0]),
    .sclk_s     (pins_s[1]),
    .mosi_s     (pins_s[2]),
    .pause_n_s  (pins_s[3]),
    .addr_strap (addr_strap),
    .wip_in     (wip_in),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .fall_ok    (fall_ok),
    .rd_phase   (rd_phase),
    .paused     (paused),
    .ld_rsp     (ld_rsp),
    .ld_stat    (ld_stat),
    .stat_byte  (stat_byte)
  );

  pot_sdo_shift u_sdo (
    .clk       (clk),
    .rst       (rst),
    .selected  (~pins_s[0]),
    .paused    (paused),
    .rd_phase  (rd_phase),
    .fall_ok   (fall_ok),
    .ld_rsp    (ld_rsp),
    .rsp_data  (rsp_data),
    .ld_stat   (ld_stat),
    .stat_byte (stat_byte),
    .sdo       (spi_miso),
    .sdo_oe    (spi_miso_oe)
  );

  p_hiz_deselect_r10: assert property (@(posedge clk) disable iff (rst)
    pins_s[0] |=> !spi_miso_oe);
endmodule

// File: tb/tb_pot_spi_decoder.sv
`timescale 1ns/1ps
module tb_pot_spi_decoder;
  localparam int HALF = 8;
  localparam int WD   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sel_n = 1'b0, spi_clk = 1'b0, spi_mosi = 1'b0, pause_n = 1'b1;
  logic [1:0] addr_strap = 2'b10;
  logic spi_miso, spi_miso_oe, cmd_valid, wip_in = 1'b0;
  logic [2:0] cmd_op;
  logic [3:0] cmd_addr;
  logic [7:0] cmd_wdata, rsp_data = 8'h00;

  int checks = 0, fails = 0, n_cmd = 0, n_up = 0, n_dn = 0;
  logic [2:0] last_op;
  logic [3:0] last_addr;
  logic [7:0] last_wd;
  logic oe_seen = 1'b0;
  logic done = 1'b0;
  logic [31:0] so_cap = '0;

  always #5 clk = ~clk;

  pot_spi_decoder dut (
    .clk(clk), .rst(rst), .spi_sel_n(spi_sel_n), .spi_clk(spi_clk),
    .spi_mosi(spi_mosi), .pause_n(pause_n), .addr_strap(addr_strap),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_data(rsp_data), .wip_in(wip_in)
  );

  function automatic logic [7:0] reg_val(input logic [3:0] a);
    return {a, ~a};
  endfunction

  // storage model: answers one cycle after a read request
  always @(posedge clk) begin
    if (!rst && cmd_valid) begin
      n_cmd++;
      last_op = cmd_op; last_addr = cmd_addr; last_wd = cmd_wdata;
      if (cmd_op == 3'd6) n_up++;
      if (cmd_op == 3'd7) n_dn++;
      rsp_data <= (cmd_op == 3'd0) ? 8'h3C : reg_val(cmd_addr);
    end
    if (spi_miso_oe) oe_seen = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    so_cap = {so_cap[30:0], spi_miso};
    spi_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_clk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    oe_seen = 1'b0;
    @(negedge clk); spi_sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send_bits(v, n);
    repeat (HALF) @(negedge clk);
    spi_sel_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R14 cmd_valid after reset", cmd_valid, 1'b0);
    check("R14 oe after reset", spi_miso_oe, 1'b0);
  endtask

  task automatic t_powerup();
    int c0 = n_cmd;
    send_bits({8'h52, 8'hA0, 8'h77}, 24);
    repeat (HALF) @(negedge clk);
    check("R12 no command without select edge", n_cmd - c0, 0);
    spi_sel_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic t_write_wiper();
    int c0 = n_cmd;
    frame({8'h52, 8'hA0, 8'h5C}, 24);
    check("R4 one write request", n_cmd - c0, 1);
    check("R3 write wiper op", last_op, 3'd1);
    check("R4 write data", last_wd, 8'h5C);
  endtask

  task automatic t_id_mismatch();
    int c0 = n_cmd;
    frame({8'h51, 8'hA0, 8'h5C}, 24);
    check("R1 address mismatch ignored", n_cmd - c0, 0);
    frame({8'h72, 8'h90, 8'h00}, 24);
    check("R1 type mismatch ignored", n_cmd - c0, 0);
    check("R1 oe low on mismatch", oe_seen, 1'b0);
  endtask

  task automatic t_read_reg();
    frame({8'h52, 8'hBE, 8'h00}, 24);
    check("R3 read register op", last_op, 3'd2);
    check("R2 address bank2 reg3", last_addr, 4'hB);
    check("R5 read data on output", so_cap[7:0], reg_val(4'hB));
    check("R5 oe during read", oe_seen, 1'b1);
    check("R10 oe low after deselect", spi_miso_oe, 1'b0);
  endtask

  task automatic t_read_wiper();
    frame({8'h52, 8'h90, 8'h00}, 24);
    check("R3 read wiper op", last_op, 3'd0);
    check("R5 wiper data", so_cap[7:0], 8'h3C);
  endtask

  task automatic t_write_reg();
    frame({8'h52, 8'hC5, 8'h81}, 24);
    check("R3 write register op", last_op, 3'd3);
    check("R2 address bank1 reg1", last_addr, 4'h5);
    check("R4 register data", last_wd, 8'h81);
  endtask

  task automatic t_partial();
    int c0 = n_cmd;
    frame({8'h52, 8'hC5, 8'h81} >> 4, 20);
    check("R4 partial frame dropped", n_cmd - c0, 0);
  endtask

  task automatic t_xfer();
    frame({8'h52, 8'hD4}, 16);
    check("R9 register to wiper op", last_op, 3'd4);
    check("R9 register to wiper addr", last_addr, 4'h1);
    frame({8'h52, 8'hE8}, 16);
    check("R9 wiper to register op", last_op, 3'd5);
    check("R9 wiper to register addr", last_addr, 4'h2);
  endtask

  task automatic t_bank();
    int c0 = n_cmd;
    frame({8'h52, 8'hA1, 8'h33}, 24);
    check("R7 write wiper bank1 ignored", n_cmd - c0, 0);
    frame({8'h52, 8'h91, 8'h00}, 24);
    check("R7 read wiper bank1 ignored", n_cmd - c0, 0);
    check("R7 oe low for bad bank", oe_seen, 1'b0);
    frame({8'h52, 8'h21, 4'b1111}, 20);
    check("R7 step bank1 ignored", n_cmd - c0, 0);
  endtask

  task automatic t_status();
    int c0 = n_cmd;
    wip_in = 1'b1;
    frame({8'h52, 8'h51, 8'h00}, 24);
    check("R6 status busy", so_cap[7:0], 8'h01);
    wip_in = 1'b0;
    frame({8'h52, 8'h51, 8'h00}, 24);
    check("R6 status idle", so_cap[7:0], 8'h00);
    check("R6 status makes no request", n_cmd - c0, 0);
  endtask

  task automatic t_step();
    int u0 = n_up, d0 = n_dn;
    frame({8'h52, 8'h20, 4'b1101}, 20);
    check("R8 step up count", n_up - u0, 3);
    check("R8 step down count", n_dn - d0, 1);
  endtask

  task automatic t_undef();
    int c0 = n_cmd;
    frame({8'h52, 8'h00, 8'hFF}, 24);
    frame({8'h52, 8'hF0, 8'hFF}, 24);
    check("R13 undefined opcode ignored", n_cmd - c0, 0);
    check("R13 oe low on undefined", oe_seen, 1'b0);
  endtask

  task automatic t_hold();
    int c0 = n_cmd;
    @(negedge clk); spi_sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send_bits({8'h52, 8'hA0, 4'h9}, 20);
    pause_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 4; k++) clk_bit(1'b1);
    pause_n = 1'b1;
    repeat (HALF) @(negedge clk);
    send_bits(4'h6, 4);
    repeat (HALF) @(negedge clk);
    spi_sel_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    check("R11 one request after pause", n_cmd - c0, 1);
    check("R11 data kept across pause", last_wd, 8'h96);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_powerup();
    t_write_wiper();
    t_id_mismatch();
    t_read_reg();
    t_read_wiper();
    t_write_reg();
    t_partial();
    t_xfer();
    t_bank();
    t_status();
    t_step();
    t_undef();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule